// File: doc/BRIEF.md
# Multiplexed Segment LCD Timing Sequencer

This block sequences the common phases of a multiplexed segment LCD running at 1/2, 1/3 or 1/4 duty. It runs from the oscillator clock. Each common phase opens with a short key-scan window. During that window the first eight segment pins serve as strobes that step across a key matrix. After the window, the display levels are applied.

For every common pin and every segment pin, the block emits a 3-bit drive-level code in place of an analog voltage. The code depends on the bias, on whether the pin is selected, on the latch bit for the active common row, and on a parity bit that inverts the drive polarity on alternate frames.

A separate serial front end supplies the settings and the 4-row segment latch. A separate key logic block consumes the key strobes and the frame pulse.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: One common phase lasts (128 << rateSel) clocks. A frame is that length times the number of active commons. Commons advance in ascending order from common 0.
- R2: The dutySel encoding is as follows: 00 gives 4 commons at 1/3 bias, 01 gives 3 commons at 1/3 bias, and 10 or 11 give 2 commons at 1/2 bias.
- R3: The first 16 clocks of every common phase form a key window. In the window, every common code is HALF and every segment code is GND, except a pin whose key strobe is active, which is VLCD.
- R4: In window K0 (common 0), keySrc bits 0 to 3 are strobed one at a time in ascending order, each for 4 clocks (two 2-clock slots). In window K1 (common 1), bits 4 to 7 are strobed the same way.
- R5: Windows K2 and K3 (commons 2 and 3) drive no key strobe.
- R6: The level codes are GND=0, THIRD=1, HALF=2, TWOTHIRD=3 and VLCD=4. At 1/3 bias with parity 0, a selected common is VLCD and an unselected common is THIRD; a lit segment (latch bit 1) is GND and an unlit segment is TWOTHIRD. Parity 1 gives GND, TWOTHIRD, VLCD and THIRD respectively.
- R7: At 1/2 bias with parity 0, a selected common is VLCD and every other common is HALF; a lit segment is GND and an unlit segment is VLCD. Parity 1 swaps VLCD and GND.
- R8: The parity bit starts at 0 after reset and inverts at every frame boundary.
- R9: When outEn is 0 or dispOn is 0, every common code and every segment code is VLCD, and ledOn is 0.
- R10: When dispOn is 0, keySrc stays 0. When outEn alone is 0, the key strobes keep running.
- R11: When ledMode is 1, the top 8 segment pins act as LED drives. ledOn[i] is the inverse of latch row 0 bit (48+i), and the segment code on those pins is GND.
- R12: frameDone is high for exactly the last clock of the last common phase of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| dutySel | input | 2 | Duty and bias select |
| rateSel | input | 2 | Frame divider select |
| dispOn | input | 1 | Display enable; also enables key scanning |
| outEn | input | 1 | Output enable |
| ledMode | input | 1 | Top 8 segment pins act as LED drives |
| segLatch | input | 224 | Segment latch; row r occupies bits r*56 to r*56+55 |
| comLevel | output | 12 | Level code of common c at bits c*3 to c*3+2 |
| segLevel | output | 168 | Level code of segment s at bits s*3 to s*3+2 |
| keySrc | output | 8 | Key-source strobes |
| ledOn | output | 8 | LED drive, 1 = lit |
| frameDone | output | 1 | One-clock pulse at the end of each frame |

## Verification
A table of duty and divider combinations measures the spacing between frameDone pulses. This separates a wrong common count, a wrong phase length and a shared 1/2-duty code.

Directed stimulus then walks one 1/4-duty frame and the start of the next. The first common row holds lit, unlit and LED bit patterns, so the key strobe order, the quiet late windows, the level choice per bias and the polarity flip each show up as distinct codes.

Further runs with the outputs disabled, the display off and the LED mode on separate the blanking path from the key-scan gating.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int LVL_W = 3;
  localparam int CIDX_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LV_GND      = 3'd0,
    LV_THIRD    = 3'd1,
    LV_HALF     = 3'd2,
    LV_TWOTHIRD = 3'd3,
    LV_VLCD     = 3'd4
  } lvl_t;

  // strobes from the timing control to the level datapath
  typedef struct packed {
    logic              window;
    logic [1:0]        srcIdx;
    logic [CIDX_W-1:0] comIdx;
    logic              parity;
    logic              halfBias;
  } seq_ctl_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int PHASE_BASE = 128,
  parameter int KEY_WIN    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] dutySel,
  input  logic [1:0] rateSel,
  output seq_ctl_t   ctl,
  output logic       frameDone
);
  localparam int TICK_W = $clog2(PHASE_BASE * 8);
  localparam int WIN_W  = $clog2(KEY_WIN);

  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] lastTick;
  logic [CIDX_W-1:0] comIdx;
  logic [CIDX_W-1:0] lastCom;
  logic              parity;
  logic              phaseEnd;

  always_comb begin
    lastTick = TICK_W'((PHASE_BASE << rateSel) - 1);
    unique case (dutySel)
      2'b00:   lastCom = 2'd3;
      2'b01:   lastCom = 2'd2;
      default: lastCom = 2'd1;
    endcase
    phaseEnd  = (tick >= lastTick);
    frameDone = phaseEnd && (comIdx >= lastCom);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick   <= '0;
      comIdx <= '0;
      parity <= 1'b0;
    end else if (phaseEnd) begin
      tick <= '0;
      if (comIdx >= lastCom) begin
        comIdx <= '0;
        parity <= ~parity;
      end else begin
        comIdx <= comIdx + 1'b1;
      end
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_comb begin
    ctl.window   = (tick < TICK_W'(KEY_WIN));
    ctl.srcIdx   = tick[WIN_W-1 -: 2];
    ctl.comIdx   = comIdx;
    ctl.parity   = parity;
    ctl.halfBias = dutySel[1];
  end

  assert_frame_wrap_R12: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (tick == '0) && (comIdx == '0));
  assert_parity_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (parity != $past(parity)));
  assert_com_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (comIdx != $past(comIdx)) |-> (tick == '0));
endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int SEG_W = 56,
  parameter int COM_N = 4,
  parameter int LED_N = 8,
  parameter int KEY_N = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seq_ctl_t                 ctl,
  input  logic                     dispOn,
  input  logic                     outEn,
  input  logic                     ledMode,
  input  logic [COM_N*SEG_W-1:0]   segLatch,
  output logic [COM_N*LVL_W-1:0]   comLevel,
  output logic [SEG_W*LVL_W-1:0]   segLevel,
  output logic [KEY_N-1:0]         keySrc,
  output logic [LED_N-1:0]         ledOn
);
  localparam int LED_BASE = SEG_W - LED_N;

  logic blank;
  logic [SEG_W-1:0] rows [COM_N];
  logic [SEG_W-1:0] rowSel;

  assign blank = !dispOn || !outEn;

  for (genvar r = 0; r < COM_N; r++) begin : g_row
    assign rows[r] = segLatch[r*SEG_W +: SEG_W];
  end
  assign rowSel = rows[ctl.comIdx];

  always_comb begin
    keySrc = '0;
    if (dispOn && ctl.window && ctl.comIdx < 2'd2)
      keySrc[{ctl.comIdx[0], ctl.srcIdx}] = 1'b1;
  end

  for (genvar i = 0; i < LED_N; i++) begin : g_led
    assign ledOn[i] = ledMode && !blank && !rows[0][LED_BASE+i];
  end

  for (genvar c = 0; c < COM_N; c++) begin : g_com
    lvl_t lvl;
    logic sel;
    assign sel = (ctl.comIdx == CIDX_W'(c));
    always_comb begin
      if (blank)           lvl = LV_VLCD;
      else if (ctl.window) lvl = LV_HALF;
      else if (sel)        lvl = ctl.parity ? LV_GND : LV_VLCD;
      else if (ctl.halfBias) lvl = LV_HALF;
      else                 lvl = ctl.parity ? LV_TWOTHIRD : LV_THIRD;
    end
    assign comLevel[c*LVL_W +: LVL_W] = lvl;
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    lvl_t lvl;
    logic keyHit;
    logic isLed;
    if (s < KEY_N) begin : g_k
      assign keyHit = keySrc[s];
    end else begin : g_nk
      assign keyHit = 1'b0;
    end
    assign isLed = ledMode && (s >= LED_BASE);
    always_comb begin
      if (blank)             lvl = LV_VLCD;
      else if (isLed)        lvl = LV_GND;
      else if (ctl.window)   lvl = keyHit ? LV_VLCD : LV_GND;
      else if (rowSel[s])    lvl = ctl.parity ? LV_VLCD : LV_GND;
      else if (ctl.halfBias) lvl = ctl.parity ? LV_GND : LV_VLCD;
      else                   lvl = ctl.parity ? LV_THIRD : LV_TWOTHIRD;
    end
    assign segLevel[s*LVL_W +: LVL_W] = lvl;
  end

  assert_blank_seg_R9: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> (segLevel == {SEG_W{3'd4}}) && (comLevel == {COM_N{3'd4}}));
  assert_led_dark_R9: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> (ledOn == '0));
  assert_key_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |-> (keySrc == '0));
  assert_key_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(keySrc));
  assert_late_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.comIdx >= 2'd2) |-> (keySrc == '0));
  assert_window_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.window |-> (keySrc == '0));
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int SEG_W      = 56,
  parameter int COM_N      = 4,
  parameter int LED_N      = 8,
  parameter int KEY_N      = 8,
  parameter int PHASE_BASE = 128,
  parameter int KEY_WIN    = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             dutySel,
  input  logic [1:0]             rateSel,
  input  logic                   dispOn,
  input  logic                   outEn,
  input  logic                   ledMode,
  input  logic [COM_N*SEG_W-1:0] segLatch,
  output logic [COM_N*3-1:0]     comLevel,
  output logic [SEG_W*3-1:0]     segLevel,
  output logic [KEY_N-1:0]       keySrc,
  output logic [LED_N-1:0]       ledOn,
  output logic                   frameDone
);
  seq_ctl_t ctl;

  lcd_seq_ctrl #(.PHASE_BASE(PHASE_BASE), .KEY_WIN(KEY_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .dutySel(dutySel), .rateSel(rateSel),
    .ctl(ctl), .frameDone(frameDone)
  );

  lcd_seq_dp #(.SEG_W(SEG_W), .COM_N(COM_N), .LED_N(LED_N), .KEY_N(KEY_N)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dispOn(dispOn), .outEn(outEn),
    .ledMode(ledMode), .segLatch(segLatch), .comLevel(comLevel),
    .segLevel(segLevel), .keySrc(keySrc), .ledOn(ledOn)
  );
endmodule

// File: tb/sim_lcd_mux_sequencer.sv
module sim_lcd_mux_sequencer;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   dutySel = 2'b00;
  logic [1:0]   rateSel = 2'd0;
  logic         dispOn = 1'b1;
  logic         outEn = 1'b1;
  logic         ledMode = 1'b0;
  logic [223:0] segLatch = '0;
  logic [11:0]  comLevel;
  logic [167:0] segLevel;
  logic [7:0]   keySrc;
  logic [7:0]   ledOn;
  logic         frameDone;

  int nChk = 0;
  int nBad = 0;
  int cur  = 0;

  localparam logic [2:0] GND = 3'd0, THIRD = 3'd1, HALF = 3'd2, TWOT = 3'd3, VLCD = 3'd4;

  // {dutySel, rateSel, expected frame length}
  localparam logic [16:0] FRAME_VEC [6] = '{
    {2'b00, 2'd0, 13'd512}, {2'b01, 2'd0, 13'd384}, {2'b10, 2'd1, 13'd512},
    {2'b11, 2'd0, 13'd256}, {2'b01, 2'd2, 13'd1536}, {2'b00, 2'd3, 13'd4096}
  };

  lcd_mux_sequencer u0 (
    .clk(clk), .rstN(rstN), .dutySel(dutySel), .rateSel(rateSel), .dispOn(dispOn),
    .outEn(outEn), .ledMode(ledMode), .segLatch(segLatch), .comLevel(comLevel),
    .segLevel(segLevel), .keySrc(keySrc), .ledOn(ledOn), .frameDone(frameDone)
  );

  always #2 clk = ~clk;

  function automatic logic [2:0] segAt(int s);
    return segLevel[s*3 +: 3];
  endfunction
  function automatic logic [2:0] comAt(int c);
    return comLevel[c*3 +: 3];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at tick %0d: actual %0h expected %0h", tag, cur, act, exp);
    end
  endtask

  task automatic restart(logic [1:0] d, logic [1:0] r);
    @(negedge clk);
    rstN = 1'b0; dutySel = d; rateSel = r;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cur = 0;
  endtask

  task automatic go(int k);
    while (cur < k) begin
      @(negedge clk);
      cur++;
    end
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    segLatch[0] = 1'b1; segLatch[1] = 1'b0;
    segLatch[55:48] = 8'hA5;
    segLatch[56] = 1'b0; segLatch[57] = 1'b1;

    // R1 R2: frame length per duty and divider
    for (int v = 0; v < 6; v++) begin
      int n;
      int guard;
      restart(FRAME_VEC[v][16:15], FRAME_VEC[v][14:13]);
      guard = 0;
      do begin @(negedge clk); guard++; end while (!frameDone && guard < 10000);
      n = 0;
      do begin @(negedge clk); n++; end while (!frameDone && n < 10000);
      chk("R1 R2 frame length", n, FRAME_VEC[v][12:0]);
    end

    // directed: 1/4 duty, fastest divider
    restart(2'b00, 2'd0);
    chk("R12 reset frameDone", frameDone, 0);
    chk("R4 K0 first strobe", keySrc, 8'h01);
    chk("R3 window seg0 strobed", segAt(0), VLCD);
    chk("R3 window seg1 idle", segAt(1), GND);
    chk("R3 window com", comAt(0), HALF);
    go(4);
    chk("R4 K0 second strobe", keySrc, 8'h02);
    chk("R3 window seg1 strobed", segAt(1), VLCD);
    go(12);
    chk("R4 K0 last strobe", keySrc, 8'h08);
    go(16);
    chk("R3 window end", keySrc, 8'h00);
    go(20);
    chk("R6 com0 selected", comAt(0), VLCD);
    chk("R6 com1 unselected", comAt(1), THIRD);
    chk("R6 seg lit", segAt(0), GND);
    chk("R6 seg unlit", segAt(1), TWOT);
    go(128);
    chk("R4 K1 first strobe", keySrc, 8'h10);
    go(140);
    chk("R4 K1 last strobe", keySrc, 8'h80);
    go(148);
    chk("R1 com1 selected", comAt(1), VLCD);
    chk("R6 row1 unlit", segAt(0), TWOT);
    chk("R6 row1 lit", segAt(1), GND);
    go(256);
    chk("R5 K2 quiet", keySrc, 8'h00);
    go(384);
    chk("R5 K3 quiet", keySrc, 8'h00);
    go(510);
    chk("R12 before end", frameDone, 0);
    go(511);
    chk("R12 end pulse", frameDone, 1);
    go(512);
    chk("R12 pulse single", frameDone, 0);
    chk("R4 K0 next frame", keySrc, 8'h01);
    go(532);
    chk("R8 R6 com0 flipped", comAt(0), GND);
    chk("R8 R6 com1 flipped", comAt(1), TWOT);
    chk("R8 R6 seg lit flipped", segAt(0), VLCD);
    chk("R8 R6 seg unlit flipped", segAt(1), THIRD);

    // R7: 1/2 bias
    restart(2'b10, 2'd0);
    go(20);
    chk("R7 com0 selected", comAt(0), VLCD);
    chk("R7 com1 unselected", comAt(1), HALF);
    chk("R7 seg lit", segAt(0), GND);
    chk("R7 seg unlit", segAt(1), VLCD);
    go(276);
    chk("R7 seg lit flipped", segAt(0), VLCD);
    chk("R7 seg unlit flipped", segAt(1), GND);

    // R9 R10: output disable keeps strobes
    restart(2'b00, 2'd0);
    outEn = 1'b0;
    go(1);
    chk("R10 outEn low keeps strobe", keySrc, 8'h01);
    chk("R9 outEn low seg", segAt(0), VLCD);
    chk("R9 outEn low com", comAt(0), VLCD);
    go(20);
    chk("R9 outEn low seg display", segAt(1), VLCD);
    outEn = 1'b1; dispOn = 1'b0;
    go(128);
    chk("R10 display off stops strobe", keySrc, 8'h00);
    chk("R9 display off seg", segAt(4), VLCD);
    dispOn = 1'b1;
    go(130);
    chk("R10 strobe resumes", keySrc, 8'h10);

    // R11: LED mode
    ledMode = 1'b1;
    go(150);
    chk("R11 led drive", ledOn, 8'h5A);
    chk("R11 led pin code", segAt(48), GND);
    outEn = 1'b0;
    go(151);
    chk("R11 R9 led blanked", ledOn, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule